// File: doc/BRIEF.md
# Page-Pool DMA Write Engine

This engine streams 32-bit words from a link receiver straight into host memory pages. Software supplies the pages. It pushes page base addresses into a free-address FIFO inside the engine. The engine takes the next address and fills that page with incoming words, which go out on a burst write port. It then places the page address and a status word into a ready FIFO, where software collects it. The engine holds no data of its own. Each input word goes out on the memory port in the same cycle it is accepted, so the processor does nothing per transfer.

An event may span several pages. Pages are used strictly in the order their addresses were pushed. A page closes when it holds the parameterised number of words or when the end-of-event word has been written. Both FIFOs report their occupancy. Back-pressure on the input covers three cases: no free page, a stalled memory port, and a full ready FIFO.

Top module: `page_dma_engine`

## Requirements
- R1: After reset, both FIFO occupancy counts are 0, `rdy_empty_o` is 1, `free_full_o` is 0, and `in_ready_o` and `mem_wvalid_o` are 0.
- R2: `free_push_i` stores `free_addr_i` and raises `free_count_o` by one unless the free FIFO is full. A push to a full FIFO is ignored: the count is unchanged and that address is never used as a page.
- R3: While no free address is available and a new page is needed, `in_ready_o` and `mem_wvalid_o` stay 0. Input resumes once an address is pushed.
- R4: Pages are filled, and their entries appear in the ready FIFO, in the order their addresses were pushed.
- R5: In the fill phase, `in_ready_o` follows `mem_wready_i`, `mem_wvalid_o` follows `in_valid_i`, and `mem_wdata_o` equals `in_data_i`. A word is transferred when valid and ready are both high. `mem_waddr_o` is the page base plus four times the page-relative word offset of the current burst's first word, and it is held for the whole burst.
- R6: Bursts are at most BURST_MAX (16) words and start at page word offsets that are multiples of BURST_MAX. `mem_wfirst_o` marks the first word of a burst. `mem_wlast_o` marks a word that fills the burst, fills the page, or carries `in_eoe_i`.
- R7: A page that fills without an end-of-event word closes with status count = PAGE_WORDS and the end-of-event flag at 0. The event continues at offset 0 of the next page.
- R8: A page closed by an end-of-event word has status count = words written to it and end-of-event flag 1. Its error flag equals `in_err_i` on that last word; `in_err_i` on any other word has no effect. Status layout: bits [CNT_W-1:0] word count, bit CNT_W end-of-event, bit CNT_W+1 error.
- R9: When a page is finished and the ready FIFO is full, the engine waits with `in_ready_o` at 0 and takes no free address. The entry is written once space appears, and no entry is lost.
- R10: The ready FIFO shows its oldest entry on `rdy_addr_o`/`rdy_status_o` while `rdy_empty_o` is 0. `rdy_pop_i` removes it and lowers `rdy_count_o`. A pop when the FIFO is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| free_push_i | input | 1 | Push a free page address |
| free_addr_i | input | ADDR_W | Free page base address |
| free_full_o | output | 1 | Free FIFO full |
| free_count_o | output | $clog2(FIFO_DEPTH+1) | Free FIFO occupancy |
| rdy_pop_i | input | 1 | Remove oldest ready entry |
| rdy_empty_o | output | 1 | Ready FIFO empty |
| rdy_addr_o | output | ADDR_W | Oldest ready page address |
| rdy_status_o | output | CNT_W+2 | Oldest ready page status |
| rdy_count_o | output | $clog2(FIFO_DEPTH+1) | Ready FIFO occupancy |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | DATA_W | Input word |
| in_eoe_i | input | 1 | Word is last of its event |
| in_err_i | input | 1 | Event error, taken on end-of-event word |
| in_ready_o | output | 1 | Input word accepted when valid |
| mem_wvalid_o | output | 1 | Memory write beat valid |
| mem_wready_i | input | 1 | Memory accepts beat |
| mem_waddr_o | output | ADDR_W | Burst byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_wfirst_o | output | 1 | First beat of burst |
| mem_wlast_o | output | 1 | Last beat of burst |

## Verification
The bench targets several corner cases. One is an event whose final word is also the page's last word: a design that checks page-full and end-of-event separately would close an empty extra page or drop the end-of-event flag. Another is an event that overflows into a second page while the memory port stalls at random; a wrong design would miscount words or cross a page or 16-word boundary within one burst. A third is a push to a full free FIFO, where a wrong design would later fill a page nobody allocated. The bench also fills the ready FIFO before a page closes, where a wrong design would overwrite or drop an entry or keep taking input. Finally, an error marker on a middle word must not reach the page status.

// File: rtl/page_dma_pkg.sv
package page_dma_pkg;
  typedef enum logic [1:0] {
    ST_GET   = 2'd0,
    ST_FILL  = 2'd1,
    ST_CLOSE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/pdm_fifo.sv
module pdm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pdm_burst_gen.sv
module pdm_burst_gen #(
  parameter int PAGE_WORDS = 1024,
  parameter int BURST_MAX  = 16,
  localparam int CNT_W  = $clog2(PAGE_WORDS + 1),
  localparam int BCNT_W = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1,
  localparam int OFF_W  = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic             eoe_i,
  output logic [CNT_W-1:0] wcnt_o,
  output logic             first_o,
  output logic             last_o,
  output logic             page_end_o,
  output logic [OFF_W-1:0] off_o
);
  logic [CNT_W-1:0]  wcnt_q, bstart_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              burst_end;

  assign burst_end  = (bcnt_q == BCNT_W'(BURST_MAX - 1));
  assign page_end_o = (wcnt_q == CNT_W'(PAGE_WORDS - 1));
  assign first_o    = (bcnt_q == '0);
  assign last_o     = burst_end || page_end_o || eoe_i;
  assign wcnt_o     = wcnt_q;
  assign off_o      = {bstart_q, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q   <= '0;
      bcnt_q   <= '0;
      bstart_q <= '0;
    end else if (clear_i) begin
      wcnt_q   <= '0;
      bcnt_q   <= '0;
      bstart_q <= '0;
    end else if (beat_i) begin
      wcnt_q <= wcnt_q + CNT_W'(1);
      if (last_o) begin
        bcnt_q   <= '0;
        bstart_q <= wcnt_q + CNT_W'(1);
      end else begin
        bcnt_q <= bcnt_q + BCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pdm_fill_ctrl.sv
module pdm_fill_ctrl
  import page_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 11,
  localparam int STS_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              free_empty_i,
  input  logic [ADDR_W-1:0] free_addr_i,
  output logic              free_pop_o,
  input  logic              rdy_full_i,
  output logic              rdy_push_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [STS_W-1:0]  status_o,
  input  logic              in_valid_i,
  input  logic              in_eoe_i,
  input  logic              in_err_i,
  output logic              in_ready_o,
  input  logic              mem_wready_i,
  output logic              mem_wvalid_o,
  output logic              beat_o,
  output logic              clear_o,
  input  logic              page_end_i,
  input  logic [CNT_W-1:0]  wcnt_i
);
  fill_state_e       st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              eoe_q, err_q, closing;

  assign in_ready_o   = (st_q == ST_FILL) && mem_wready_i;
  assign mem_wvalid_o = (st_q == ST_FILL) && in_valid_i;
  assign beat_o       = in_ready_o && in_valid_i;
  assign free_pop_o   = (st_q == ST_GET) && !free_empty_i;
  assign clear_o      = free_pop_o;
  assign rdy_push_o   = (st_q == ST_CLOSE) && !rdy_full_i;
  assign closing      = beat_o && (page_end_i || in_eoe_i);
  assign base_o       = base_q;
  assign status_o     = {err_q, eoe_q, cnt_q};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_GET:   if (free_pop_o) st_d = ST_FILL;
      ST_FILL:  if (closing)    st_d = ST_CLOSE;
      ST_CLOSE: if (rdy_push_o) st_d = ST_GET;
      default:                  st_d = ST_GET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_GET;
      base_q <= '0;
      cnt_q  <= '0;
      eoe_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (free_pop_o) base_q <= free_addr_i;
      if (closing) begin
        cnt_q <= wcnt_i + CNT_W'(1);
        eoe_q <= in_eoe_i;
        err_q <= in_eoe_i && in_err_i;
      end
    end
  end
endmodule

// File: rtl/page_dma_engine.sv
module page_dma_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 1024,
  parameter int BURST_MAX  = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W  = $clog2(PAGE_WORDS + 1),
  localparam int STS_W  = CNT_W + 2,
  localparam int OFF_W  = CNT_W + 2,
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              free_push_i,
  input  logic [ADDR_W-1:0] free_addr_i,
  output logic              free_full_o,
  output logic [FCNT_W-1:0] free_count_o,
  input  logic              rdy_pop_i,
  output logic              rdy_empty_o,
  output logic [ADDR_W-1:0] rdy_addr_o,
  output logic [STS_W-1:0]  rdy_status_o,
  output logic [FCNT_W-1:0] rdy_count_o,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_eoe_i,
  input  logic              in_err_i,
  output logic              in_ready_o,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wfirst_o,
  output logic              mem_wlast_o
);
  logic              free_empty, free_pop;
  logic [ADDR_W-1:0] free_head;
  logic              rdy_full, rdy_push;
  logic [ADDR_W-1:0] page_base;
  logic [STS_W-1:0]  page_status;
  logic              beat, clear, page_end, first, last;
  logic [CNT_W-1:0]  wcnt;
  logic [OFF_W-1:0]  off;

  pdm_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) i_free_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (free_push_i),
    .data_i  (free_addr_i),
    .pop_i   (free_pop),
    .data_o  (free_head),
    .empty_o (free_empty),
    .full_o  (free_full_o),
    .count_o (free_count_o)
  );

  pdm_fifo #(.W(ADDR_W + STS_W), .DEPTH(FIFO_DEPTH)) i_rdy_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rdy_push),
    .data_i  ({page_base, page_status}),
    .pop_i   (rdy_pop_i),
    .data_o  ({rdy_addr_o, rdy_status_o}),
    .empty_o (rdy_empty_o),
    .full_o  (rdy_full),
    .count_o (rdy_count_o)
  );

  pdm_fill_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_fill_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .free_empty_i (free_empty),
    .free_addr_i  (free_head),
    .free_pop_o   (free_pop),
    .rdy_full_i   (rdy_full),
    .rdy_push_o   (rdy_push),
    .base_o       (page_base),
    .status_o     (page_status),
    .in_valid_i   (in_valid_i),
    .in_eoe_i     (in_eoe_i),
    .in_err_i     (in_err_i),
    .in_ready_o   (in_ready_o),
    .mem_wready_i (mem_wready_i),
    .mem_wvalid_o (mem_wvalid_o),
    .beat_o       (beat),
    .clear_o      (clear),
    .page_end_i   (page_end),
    .wcnt_i       (wcnt)
  );

  pdm_burst_gen #(.PAGE_WORDS(PAGE_WORDS), .BURST_MAX(BURST_MAX)) i_burst_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .beat_i     (beat),
    .eoe_i      (in_eoe_i),
    .wcnt_o     (wcnt),
    .first_o    (first),
    .last_o     (last),
    .page_end_o (page_end),
    .off_o      (off)
  );

  assign mem_waddr_o  = page_base + ADDR_W'(off);
  assign mem_wdata_o  = in_data_i;
  assign mem_wfirst_o = mem_wvalid_o && first;
  assign mem_wlast_o  = mem_wvalid_o && last;
endmodule

// File: rtl/page_dma_checker.sv
module page_dma_checker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_WORDS = 1024,
  parameter int BURST_MAX  = 16,
  parameter int CNT_W      = 11,
  localparam int BC_W = $clog2(BURST_MAX + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              beat_i,
  input logic              wfirst_i,
  input logic              wlast_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic              rdy_push_i,
  input logic              rdy_full_i,
  input logic [CNT_W-1:0]  rdy_cnt_i,
  input logic              free_pop_i,
  input logic              free_empty_i
);
  logic [BC_W-1:0]  bcnt_q;
  logic [CNT_W-1:0] pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      pw_q   <= '0;
    end else begin
      if (beat_i) bcnt_q <= wlast_i ? '0 : bcnt_q + BC_W'(1);
      if (rdy_push_i)  pw_q <= '0;
      else if (beat_i) pw_q <= pw_q + CNT_W'(1);
    end
  end

  assert_burst_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (bcnt_q < BC_W'(BURST_MAX)));
  assert_first_mark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (wfirst_i == (bcnt_q == '0)));
  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !wlast_i) |=> $stable(waddr_i));
  assert_page_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (pw_q < CNT_W'(PAGE_WORDS)));
  assert_status_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_push_i |-> (rdy_cnt_i == pw_q));
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_push_i |-> !rdy_full_i);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_pop_i |-> !free_empty_i);
endmodule

bind page_dma_engine page_dma_checker #(
  .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .BURST_MAX(BURST_MAX), .CNT_W(CNT_W)
) i_page_dma_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_i       (beat),
  .wfirst_i     (mem_wfirst_o),
  .wlast_i      (mem_wlast_o),
  .waddr_i      (mem_waddr_o),
  .rdy_push_i   (rdy_push),
  .rdy_full_i   (rdy_full),
  .rdy_cnt_i    (page_status[CNT_W-1:0]),
  .free_pop_i   (free_pop),
  .free_empty_i (free_empty)
);

// File: tb/test_page_dma_engine.sv
module test_page_dma_engine;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int PW  = 40;
  localparam int BM  = 16;
  localparam int DEP = 4;
  localparam int CW  = $clog2(PW + 1);
  localparam int SW  = CW + 2;
  localparam int FW  = $clog2(DEP + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic free_push_i = 1'b0, rdy_pop_i = 1'b0;
  logic [AW-1:0] free_addr_i = '0;
  logic in_valid_i = 1'b0, in_eoe_i = 1'b0, in_err_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic mem_wready_i = 1'b1;
  logic free_full_o, rdy_empty_o, in_ready_o, mem_wvalid_o, mem_wfirst_o, mem_wlast_o;
  logic [FW-1:0] free_count_o, rdy_count_o;
  logic [AW-1:0] rdy_addr_o, mem_waddr_o;
  logic [SW-1:0] rdy_status_o;
  logic [DW-1:0] mem_wdata_o;

  int n_tests = 0, n_fail = 0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  logic [AW-1:0] exp_pages[$];
  logic [AW-1:0] exp_raddr[$];
  logic [SW-1:0] exp_rsts[$];
  logic [AW-1:0] m_page = '0;
  int m_widx = 0;

  always #4 clk_i = ~clk_i;

  page_dma_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW), .BURST_MAX(BM),
                    .FIFO_DEPTH(DEP)) i_page_dma_engine (.*);

  always @(posedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_wready_i <= stall_en ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // beat monitor: model of addresses, markers and page closing
  always @(negedge clk_i) begin
    if (rst_ni && mem_wvalid_o && mem_wready_i) begin
      logic [AW-1:0] ea;
      bit ef, el;
      if (m_widx == 0) begin
        chk(exp_pages.size() > 0, "R4", "beat without allocated page", 0, 1);
        if (exp_pages.size() > 0) m_page = exp_pages.pop_front();
      end
      ea = m_page + AW'(((m_widx / BM) * BM) * 4);
      ef = (m_widx % BM) == 0;
      el = ((m_widx % BM) == BM - 1) || (m_widx == PW - 1) || in_eoe_i;
      chk(mem_waddr_o == ea, "R5", "burst address", mem_waddr_o, ea);
      chk(mem_wdata_o == in_data_i, "R5", "write data", mem_wdata_o, in_data_i);
      chk({mem_wfirst_o, mem_wlast_o} == {ef, el}, "R6", "first/last marks",
          {mem_wfirst_o, mem_wlast_o}, {ef, el});
      m_widx++;
      if (m_widx == PW || in_eoe_i) begin
        exp_raddr.push_back(m_page);
        exp_rsts.push_back({in_eoe_i & in_err_i, in_eoe_i, CW'(m_widx)});
        m_widx = 0;
      end
    end
  end

  task automatic push_free(input logic [AW-1:0] a);
    free_push_i = 1'b1; free_addr_i = a;
    @(posedge clk_i); #1;
    free_push_i = 1'b0;
  endtask

  task automatic send_word(input logic [DW-1:0] d, input bit eoe, input bit err);
    bit acc;
    in_valid_i = 1'b1; in_data_i = d; in_eoe_i = eoe; in_err_i = err;
    do begin
      @(negedge clk_i); acc = in_ready_o;
      @(posedge clk_i); #1;
    end while (!acc);
    in_valid_i = 1'b0; in_eoe_i = 1'b0; in_err_i = 1'b0;
  endtask

  task automatic send_event(input int n, input int tag, input int mid_err, input bit eoe_err);
    for (int i = 0; i < n; i++)
      send_word(DW'(tag * 1000 + i), i == n - 1, (i == n - 1) ? eoe_err : (i == mid_err));
  endtask

  task automatic pop_check();
    int w = 0;
    @(negedge clk_i);
    while (rdy_empty_o && w < 100) begin @(negedge clk_i); w++; end
    chk(!rdy_empty_o, "R10", "entry present", rdy_empty_o, 0);
    if (exp_raddr.size() > 0) begin
      logic [AW-1:0] ea = exp_raddr.pop_front();
      logic [SW-1:0] es = exp_rsts.pop_front();
      chk(rdy_addr_o == ea, "R4", "ready page order", rdy_addr_o, ea);
      if (es[CW]) chk(rdy_status_o == es, "R8", "eoe page status", rdy_status_o, es);
      else        chk(rdy_status_o == es, "R7", "full page status", rdy_status_o, es);
    end else chk(1'b0, "R4", "unexpected ready entry", rdy_addr_o, 0);
    @(posedge clk_i); #1;
    rdy_pop_i = 1'b1;
    @(posedge clk_i); #1;
    rdy_pop_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(free_count_o == 0 && rdy_count_o == 0, "R1", "counts", {free_count_o, rdy_count_o}, 0);
    chk(rdy_empty_o && !free_full_o, "R1", "empty/full flags", {rdy_empty_o, free_full_o}, 2'b10);
    chk(!in_ready_o && !mem_wvalid_o, "R1", "ready/valid", {in_ready_o, mem_wvalid_o}, 0);
  endtask

  task automatic t_free_fill();
    push_free(32'h1000_0000);
    for (int i = 1; i < 5; i++) begin
      push_free(32'h1000_0000 + AW'(i * 'h1000));
    end
    exp_pages = {32'h1000_0000, 32'h1000_1000, 32'h1000_2000, 32'h1000_3000, 32'h1000_4000};
    @(negedge clk_i);
    chk(free_count_o == FW'(DEP) && free_full_o, "R2", "free fifo filled", free_count_o, DEP);
    @(posedge clk_i); #1;
    push_free(32'hDEAD_0000);
    @(negedge clk_i);
    chk(free_count_o == FW'(DEP), "R2", "push to full ignored", free_count_o, DEP);
    @(posedge clk_i); #1;
  endtask

  task automatic t_events();
    send_event(10, 1, 4, 1'b0);         // R8: mid error ignored
    stall_en = 1'b1;
    send_event(45, 2, -1, 1'b1);        // R7 then R8 with error
    stall_en = 1'b0;
    send_event(40, 3, -1, 1'b0);        // page end coincides with eoe
  endtask

  task automatic t_ready_full();
    send_event(1, 4, -1, 1'b0);         // on page E, close stalls
    push_free(32'h1000_5000);
    exp_pages.push_back(32'h1000_5000);
    in_valid_i = 1'b1; in_data_i = 32'h5000; in_eoe_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      chk(!in_ready_o, "R9", "input held while ready full", in_ready_o, 0);
    end
    chk(rdy_count_o == FW'(DEP), "R9", "ready count holds", rdy_count_o, DEP);
    chk(free_count_o == 1, "R9", "no free address taken", free_count_o, 1);
    @(posedge clk_i); #1;
    pop_check();
    send_word(32'h5000, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) pop_check();
  endtask

  task automatic t_no_free();
    in_valid_i = 1'b1; in_data_i = 32'h6000; in_eoe_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk(!in_ready_o && !mem_wvalid_o, "R3", "stall without page",
          {in_ready_o, mem_wvalid_o}, 0);
    end
    @(posedge clk_i); #1;
    push_free(32'h1000_6000);
    exp_pages.push_back(32'h1000_6000);
    send_word(32'h6000, 1'b1, 1'b0);
    pop_check();
  endtask

  task automatic t_empty_pop();
    @(posedge clk_i); #1;
    rdy_pop_i = 1'b1;
    @(posedge clk_i); #1;
    rdy_pop_i = 1'b0;
    @(negedge clk_i);
    chk(rdy_count_o == 0 && rdy_empty_o, "R10", "pop on empty ignored", rdy_count_o, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_free_fill();
    t_events();
    t_ready_full();
    t_no_free();
    t_empty_pop();
    chk(exp_raddr.size() == 0, "R9", "all entries delivered", exp_raddr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule